// File: doc/BRIEF.md
# Byte-Serial Memory Logical Comparator

This block decides how two byte strings of equal length in memory order against each other, treating each string as one unsigned binary number whose most significant byte sits at the lowest address. A single start pulse supplies the base address of each string and a length code. The block then reads the strings through a synchronous byte-read port: it places an address, and the data comes back on the following cycle. It reads one byte from the first string, then the matching byte from the second string, and compares the pair. It moves toward higher addresses until a pair differs or until the final pair has been compared.

The block only issues reads and never writes memory. The contents of each string are treated as raw bytes, so the digit encoding inside them does not matter. When the walk ends, the block pulses `done` for one cycle and presents a two-bit condition code. That code holds until a later comparison finishes, so the surrounding sequencer can test it at any time.

Top module: `byte_field_comparator`

## Requirements
- R1: After reset, and at any point where reset is applied, `busy`, `done` and `rd_en` are 0 and `cc` is 0.
- R2: A length code of n compares n+1 byte pairs when the strings are equal, issues exactly 2(n+1) reads, and leaves `cc` = 0 (equal).
- R3: Reads alternate first string, then second string, starting at the two base addresses and stepping each address by one per pair (first-string read k at base_a+k, second-string read k at base_b+k).
- R4: Bytes are compared as unsigned 8-bit values. When the first string's byte is the larger one at the first differing pair, `cc` = 2; the code value 3 never appears.
- R5: When the first string's byte is the smaller one at the first differing pair, `cc` = 1.
- R6: The walk stops at the first differing pair. If that pair has index k, exactly 2(k+1) reads are issued and bytes beyond it have no effect on `cc`.
- R7: `done` is high for exactly one cycle, `busy` is low in that cycle, and `cc` holds its value from then until another comparison finishes.
- R8: A `start` pulse while `busy` is high is ignored: the running comparison's reads, result and timing are unchanged.
- R9: Addresses wrap modulo 2^ADDR_W, so a string may cross the top of the address space.
- R10: Each pair takes three cycles (first read, second read, compare). `done` therefore rises 3m clock edges after the edge that accepts `start`, where m is the number of pairs compared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a comparison (accepted only when idle) |
| base_a | input | ADDR_W | Lowest address of the first string |
| base_b | input | ADDR_W | Lowest address of the second string |
| len_code | input | LEN_W | Byte count minus one |
| rd_en | output | 1 | Read request this cycle |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Comparison in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| cc | output | 2 | 0 equal, 1 first lower, 2 first higher |

## Verification
The bench builds the block with ADDR_W = 8 and LEN_W = 4. The narrow address puts a string that crosses address 0xFF within reach of a 256-byte memory model. The 4-bit length code allows the largest legal length (16 bytes) to be tested alongside the single-byte case. Each vector places deliberately contrary bytes after the first difference, so a walk that runs past it would change the code or the read count. The vectors also include differences where the signed order would be reversed (0x7F against 0x80), which exposes any signed comparison.

// File: rtl/cmpl_pkg.sv
// Package: shared types for the byte-serial comparator.
// Assumes: nothing beyond IEEE 1800-2017.
package cmpl_pkg;

    // Sequencer phases: one pair costs FETCH_A, FETCH_B, JUDGE.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_FETCH_A = 2'd1,
        PH_FETCH_B = 2'd2,
        PH_JUDGE   = 2'd3
    } phase_t;

    // Condition code values presented on the cc port.
    localparam logic [1:0] CC_EQUAL      = 2'd0;
    localparam logic [1:0] CC_FIRST_LOW  = 2'd1;
    localparam logic [1:0] CC_FIRST_HIGH = 2'd2;

endpackage

// File: rtl/cmpl_addr_gen.sv
// Module: address and length tracker.
// Holds one pointer per string and the pairs left to compare. Load
// copies the bases and the length code; step advances both pointers
// and counts down. Assumes load and step are never high together.
module cmpl_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [LEN_W-1:0]  len_code,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b,
    output logic              last
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [LEN_W-1:0]  LEN_ONE  = {{(LEN_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] ptr_a_q, ptr_b_q;
    logic [LEN_W-1:0]  left_q;

    // Pointer and remaining-count registers; wrap is natural modulo 2^ADDR_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_a_q <= '0;
            ptr_b_q <= '0;
            left_q  <= '0;
        end else if (load) begin
            ptr_a_q <= base_a;
            ptr_b_q <= base_b;
            left_q  <= len_code;
        end else if (step) begin
            ptr_a_q <= ptr_a_q + ADDR_ONE;
            ptr_b_q <= ptr_b_q + ADDR_ONE;
            left_q  <= left_q - LEN_ONE;
        end
    end

    // Outputs to the sequencer and the address mux.
    always_comb begin
        addr_a = ptr_a_q;
        addr_b = ptr_b_q;
        last   = (left_q == '0);
    end

    // Both pointers advance together by one per step (R3, R9).
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> (addr_a == $past(addr_a) + ADDR_ONE) &&
                          (addr_b == $past(addr_b) + ADDR_ONE));

endmodule

// File: rtl/cmpl_byte_judge.sv
// Module: byte capture, compare and result register.
// Captures the first-string byte when it returns, compares it with the
// second-string byte on the read data bus, and loads the condition code
// when the sequencer reports the end of the walk. Assumes rd_data holds
// the second-string byte in the cycle where finish is high.
module cmpl_byte_judge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_a,
    input  logic       finish,
    input  logic [7:0] rd_data,
    output logic       mismatch,
    output logic [1:0] cc
);
    import cmpl_pkg::*;

    logic [7:0] byte_a_q;
    logic [1:0] cc_q;
    logic       a_high;

    // Hold the first-string byte of the current pair.
    always_ff @(posedge clk) begin
        if (!rst_n)     byte_a_q <= '0;
        else if (cap_a) byte_a_q <= rd_data;
    end

    // Unsigned comparison of the pair.
    always_comb begin
        mismatch = (byte_a_q != rd_data);
        a_high   = (byte_a_q >  rd_data);
    end

    // Result register, loaded only at the end of a walk.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc_q <= CC_EQUAL;
        else if (finish)
            cc_q <= !mismatch ? CC_EQUAL : (a_high ? CC_FIRST_HIGH : CC_FIRST_LOW);
    end

    assign cc = cc_q;

    // The result holds between walks (R7).
    assert_cc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(cc));

    // Only three code values are ever produced (R4).
    assert_cc_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cc != 2'b11);

endmodule

// File: rtl/cmpl_ctrl.sv
// Module: pair sequencer.
// Walks FETCH_A -> FETCH_B -> JUDGE for each pair and ends the walk on
// a mismatch or after the last pair. Issues at most one read per cycle.
// With one-cycle read latency, each read's data is back before the next
// read is needed. A start seen outside IDLE is dropped.
module cmpl_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last,
    input  logic mismatch,
    output logic busy,
    output logic rd_en,
    output logic sel_b,
    output logic load,
    output logic step,
    output logic cap_a,
    output logic finish,
    output logic done
);
    import cmpl_pkg::*;

    phase_t phase_q, phase_d;
    logic   done_q;

    // Next-phase and strobe decode.
    always_comb begin
        phase_d = phase_q;
        rd_en   = 1'b0;
        sel_b   = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        cap_a   = 1'b0;
        finish  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    phase_d = PH_FETCH_A;
                end
            end
            PH_FETCH_A: begin
                rd_en   = 1'b1;
                phase_d = PH_FETCH_B;
            end
            PH_FETCH_B: begin
                rd_en   = 1'b1;
                sel_b   = 1'b1;
                cap_a   = 1'b1;
                phase_d = PH_JUDGE;
            end
            PH_JUDGE: begin
                if (mismatch || last) begin
                    finish  = 1'b1;
                    phase_d = PH_IDLE;
                end else begin
                    step    = 1'b1;
                    phase_d = PH_FETCH_A;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Done pulse, registered one edge after the final compare.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    assign busy = (phase_q != PH_IDLE);
    assign done = done_q;

    // Done is a single-cycle pulse (R7).
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Done coincides with the return to idle (R7).
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // A start while busy neither restarts nor drops the walk (R8).
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> busy || done);

endmodule

// File: rtl/byte_field_comparator.sv
// Module: byte-serial unsigned comparator of two equal-length memory strings.
// Reads byte k of the first string, then byte k of the second, and
// compares them. It moves from the lowest address upward and stops at
// the first differing pair or after len_code+1 pairs. It never writes
// memory. Assumes a read port with fixed one-cycle latency.
module byte_field_comparator #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [LEN_W-1:0]  len_code,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        cc
);

    logic              last, mismatch, sel_b, load, step, cap_a, finish;
    logic [ADDR_W-1:0] addr_a, addr_b;

    cmpl_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .last     (last),
        .mismatch (mismatch),
        .busy     (busy),
        .rd_en    (rd_en),
        .sel_b    (sel_b),
        .load     (load),
        .step     (step),
        .cap_a    (cap_a),
        .finish   (finish),
        .done     (done)
    );

    cmpl_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .base_a   (base_a),
        .base_b   (base_b),
        .len_code (len_code),
        .addr_a   (addr_a),
        .addr_b   (addr_b),
        .last     (last)
    );

    cmpl_byte_judge u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_a    (cap_a),
        .finish   (finish),
        .rd_data  (rd_data),
        .mismatch (mismatch),
        .cc       (cc)
    );

    // Address mux: the second-string pointer drives the bus in its fetch phase.
    always_comb rd_addr = sel_b ? addr_b : addr_a;

    // No read is issued while idle (R1).
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en);

endmodule

// File: tb/sim_byte_field_comparator.sv
module sim_byte_field_comparator;

    localparam int AW = 8;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_a = '0, base_b = '0;
    logic [LW-1:0] len_code = '0;
    logic          rd_en, busy, done;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic [1:0]    cc;

    logic [7:0]    mem [256];
    logic [AW-1:0] rlog [64];
    int            nrd = 0;
    int            n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    byte_field_comparator #(.ADDR_W(AW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_a(base_a), .base_b(base_b),
        .len_code(len_code), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .cc(cc)
    );

    // Memory model: one-cycle read latency.
    always @(posedge clk) rd_data <= mem[rd_addr];

    // Read monitor.
    always @(posedge clk) if (rst_n && rd_en) begin
        if (nrd < 64) rlog[nrd] = rd_addr;
        nrd = nrd + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Vector: {base_a, base_b, len, diff index (31 none), a byte, b byte, cc}
    localparam int NV = 8;
    localparam logic [42:0] VEC [NV] = '{
        {8'h10, 8'h40, 4'd7,  5'd31, 8'h00, 8'h00, 2'd0},  // R2 equal 8 bytes
        {8'h10, 8'h40, 4'd7,  5'd7,  8'h46, 8'h44, 2'd2},  // R4 last byte high
        {8'h20, 8'h60, 4'd3,  5'd0,  8'h7F, 8'h80, 2'd1},  // R5 unsigned low
        {8'h10, 8'h40, 4'd15, 5'd15, 8'h00, 8'h01, 2'd1},  // R5 max length
        {8'h30, 8'h70, 4'd0,  5'd31, 8'h00, 8'h00, 2'd0},  // R2 single byte
        {8'h30, 8'h70, 4'd0,  5'd0,  8'hFF, 8'hFE, 2'd2},  // R4 single byte high
        {8'hFC, 8'h80, 4'd7,  5'd5,  8'h80, 8'h7F, 2'd2},  // R9 wrap, R6 early
        {8'h10, 8'h40, 4'd9,  5'd4,  8'h12, 8'h21, 2'd1}   // R6 early stop
    };

    // Lay out both strings; bytes after the difference lean the other way.
    task automatic fill(input logic [7:0] a, input logic [7:0] b, input int d,
                        input logic [7:0] av, input logic [7:0] bv);
        for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
        for (int j = 0; j < 16; j++) begin
            logic [7:0] p;
            p = 8'(j * 29 + 3);
            mem[8'(a + j)] = p;
            mem[8'(b + j)] = p;
            if (j == d) begin
                mem[8'(a + j)] = av;
                mem[8'(b + j)] = bv;
            end else if (d != 31 && j > d) begin
                mem[8'(a + j)] = (av > bv) ? 8'h00 : 8'hFF;
                mem[8'(b + j)] = (av > bv) ? 8'hFF : 8'h00;
            end
        end
    endtask

    // Launch one comparison; returns the edges from acceptance to done.
    task automatic run(input logic [7:0] a, input logic [7:0] b, input logic [3:0] l,
                       input int poke_at, output int lat);
        int cyc;
        @(negedge clk);
        nrd = 0;
        base_a = a; base_b = b; len_code = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            if (cyc == poke_at) begin
                start = 1'b1; base_a = b; base_b = a; len_code = 4'd0;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        if (cyc >= 200) chk(1'b0, "watchdog", cyc, 0);
        lat = cyc - 1;
    endtask

    initial begin
        int lat, m, d;
        logic [7:0] a, b;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !rd_en && cc == 2'd0, "R1 reset", {busy, done, rd_en, cc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_en, "R1 idle after reset", {busy, rd_en}, 0);

        for (int v = 0; v < NV; v++) begin
            a = VEC[v][42:35]; b = VEC[v][34:27]; d = int'(VEC[v][22:18]);
            fill(a, b, d, VEC[v][17:10], VEC[v][9:2]);
            m = (d != 31 && d <= int'(VEC[v][26:23])) ? d + 1 : int'(VEC[v][26:23]) + 1;
            run(a, b, VEC[v][26:23], -1, lat);
            chk(cc == VEC[v][1:0], "R4 R5 R2 result code", cc, VEC[v][1:0]);
            chk(nrd == 2 * m, "R6 R2 read count", nrd, 2 * m);
            chk(lat == 3 * m, "R10 latency", lat, 3 * m);
            chk(!busy, "R7 busy low at done", busy, 0);
            for (int r = 0; r < 2 * m && r < 64; r++) begin
                logic [7:0] ea;
                ea = ((r % 2) == 0) ? 8'(a + r / 2) : 8'(b + r / 2);
                chk(rlog[r] == ea, "R3 R9 read address", rlog[r], ea);
            end
            @(negedge clk);
            chk(!done, "R7 done single cycle", done, 0);
        end

        // R7: result holds while idle
        begin
            logic [1:0] held;
            held = cc;
            repeat (6) @(negedge clk);
            chk(cc == held && !done, "R7 cc holds", cc, held);
        end

        // R8: start while busy ignored
        fill(8'h10, 8'h40, 2, 8'h01, 8'h09);
        run(8'h10, 8'h40, 4'd7, 4, lat);
        chk(cc == 2'd1, "R8 result unchanged", cc, 1);
        chk(nrd == 6, "R8 read count unchanged", nrd, 6);
        chk(lat == 9, "R8 timing unchanged", lat, 9);
        chk(rlog[0] == 8'h10 && rlog[5] == 8'h42, "R8 addresses unchanged", rlog[5], 8'h42);

        // R1: reset in mid-walk
        fill(8'h10, 8'h40, 31, 8'h00, 8'h00);
        @(negedge clk);
        base_a = 8'h10; base_b = 8'h40; len_code = 4'd15; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy, "R1 walk running before reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !rd_en && cc == 2'd0, "R1 reset mid-walk",
            {busy, done, rd_en, cc}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Global watchdog.
    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule